// File: doc/BRIEF.md
# Configurable Event Counter with Edge Select

This block counts events for a microcontroller-style peripheral set. One control byte chooses where the events come from. The first choice is the internal instruction-cycle tick, a one-clock strobe supplied by the core. The second choice is edges on an external counter pin, either rising or falling, as selected. The same byte turns counting on and off and selects the count length. The count is either a narrow low byte or a full two-byte value, in which the high byte takes the carry out of the low byte.

The external pin is asynchronous to the block clock. It passes through a two-flop synchroniser and then an edge detector. The edge detector keeps its history up to date even while counting is off. The control byte and the count can both be read back. A pin-mode output tells the surrounding I/O logic whether the counter pin is free to act as an ordinary bidirectional pin.

Top module: `event_counter`

## Requirements
- R1: While the count-enable bit (control bit 6) is 0, the count does not change.
- R2: With control bit 5 at 0, the count advances by one on every clock edge where `cycle_tick` is 1 and counting is enabled, and `ext_pin` has no effect.
- R3: With control bit 5 at 1, the count advances on edges of `ext_pin`. Control bit 4 at 0 selects low-to-high and at 1 selects high-to-low. A pin change set up before clock edge k shows in `count_q` after edge k+2. `cycle_tick` has no effect in this mode.
- R4: `pin_is_gpio` is 1 exactly when control bit 5 is 0, so the counter pin is then released as a general-purpose pin.
- R5: With control bit 7 at 0 (narrow mode), `count_q[15:8]` reads 0 and the low byte wraps from 0xFF to 0x00 without any carry. The stored high byte keeps its value.
- R6: With control bit 7 at 1 (wide mode), `count_q` is a 16-bit count. The high byte advances on a low-byte carry, and the count wraps from 0xFFFF to 0x0000.
- R7: A write with `ctrl_we` high stores `ctrl_wdata[7:4]` at that clock edge, and the new setting governs counting from the next cycle. Bits 3:0 are ignored and read as 0.
- R8: The edge history tracks the pin while counting is disabled. Enabling the counter while the pin already sits at its post-edge level produces no count.
- R9: A low `rst_n` at a clock edge clears the count and the whole control byte, so the default is disabled, internal source, rising edge and narrow mode.
- R10: Each clock edge adds at most one to the count, and one pin edge adds exactly one, however long the pin then holds its level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ctrl_we | input | 1 | Control byte write strobe |
| ctrl_wdata | input | 8 | Control byte write data |
| cycle_tick | input | 1 | Internal instruction-cycle strobe |
| ext_pin | input | 1 | Asynchronous external counter pin |
| ctrl_q | output | 8 | Control byte read-back |
| count_q | output | 16 | Count read-back (high byte zero in narrow mode) |
| pin_is_gpio | output | 1 | 1 when the counter pin is free for general I/O |

## Verification
A wrong control bit shows on `ctrl_q` in the cycle after the write. It also shows as a count that moves when it should hold, or holds when it should move, within one tick or within three edges of a pin change. A stale or missing edge history shows at once as an extra count when the counter is enabled at the active pin level, or as a count on the wrong polarity. Carry and wrap faults only appear when a byte boundary is crossed. For that reason the bench runs the narrow count through 0xFF and the wide count through 0xFFFF, and compares the count against an arithmetic model in every cycle.

// File: rtl/evc_pkg.sv
// Shared definitions for the event counter: control-byte field positions,
// the decoded configuration type and pack/unpack helpers.
package evc_pkg;

    localparam int CTRL_W   = 8;
    localparam int POS_WIDE = 7;   // high byte enable
    localparam int POS_EN   = 6;   // count enable
    localparam int POS_SRC  = 5;   // 1 = external pin, 0 = cycle tick
    localparam int POS_EDGE = 4;   // 1 = falling, 0 = rising

    typedef struct packed {
        logic wide;
        logic en;
        logic src_ext;
        logic edge_fall;
    } evc_cfg_t;

    // Decode a control byte into the configuration struct.
    function automatic evc_cfg_t cfg_from_byte(input logic [CTRL_W-1:0] b);
        evc_cfg_t c;
        c.wide      = b[POS_WIDE];
        c.en        = b[POS_EN];
        c.src_ext   = b[POS_SRC];
        c.edge_fall = b[POS_EDGE];
        return c;
    endfunction

    // Encode the configuration struct back into a control byte, spare bits zero.
    function automatic logic [CTRL_W-1:0] cfg_to_byte(input evc_cfg_t c);
        logic [CTRL_W-1:0] b;
        b           = '0;
        b[POS_WIDE] = c.wide;
        b[POS_EN]   = c.en;
        b[POS_SRC]  = c.src_ext;
        b[POS_EDGE] = c.edge_fall;
        return b;
    endfunction

endpackage

// File: rtl/evc_sync.sv
// Multi-stage synchroniser for one asynchronous input.
// Assumes the input is a slow level relative to clk; output lags by STAGES edges.
module evc_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic sync_out
);

    logic [STAGES-1:0] chain;

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                // First stage: capture the raw asynchronous level.
                always_ff @(posedge clk) begin
                    if (!rst_n) chain[0] <= 1'b0;
                    else        chain[0] <= async_in;
                end
            end else begin : g_rest
                // Later stages: pass the level along the chain.
                always_ff @(posedge clk) begin
                    if (!rst_n) chain[s] <= 1'b0;
                    else        chain[s] <= chain[s-1];
                end
            end
        end
    endgenerate

    assign sync_out = chain[STAGES-1];

endmodule

// File: rtl/evc_edge.sv
// Polarity-selectable edge detector on a synchronised level.
// The history flop updates every cycle, regardless of any enable, so a
// level that is already present never reads as a fresh edge.
module evc_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic level,
    input  logic sel_fall,
    output logic hit
);

    logic hist;

    // Remember the previous synchronised level.
    always_ff @(posedge clk) begin
        if (!rst_n) hist <= 1'b0;
        else        hist <= level;
    end

    // Flag the chosen transition between history and current level.
    always_comb begin
        if (sel_fall) hit = hist & ~level;
        else          hit = ~hist & level;
    end

endmodule

// File: rtl/evc_ctrl.sv
// Control register: keeps the defined upper bits of the written byte and
// presents both the decoded configuration and a read-back byte.
module evc_ctrl
    import evc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [CTRL_W-1:0] wdata,
    output evc_cfg_t          cfg,
    output logic [CTRL_W-1:0] rdata
);

    evc_cfg_t cfg_r;

    // Load the configuration on a write; clear it on reset.
    always_ff @(posedge clk) begin
        if (!rst_n)  cfg_r <= '0;
        else if (we) cfg_r <= cfg_from_byte(wdata);
    end

    assign cfg   = cfg_r;
    assign rdata = cfg_to_byte(cfg_r);

endmodule

// File: rtl/evc_count.sv
// Two-segment counter: a low segment always counts; the high segment takes
// the low carry only in wide mode. In narrow mode the high segment holds
// and reads as zero.
module evc_count #(
    parameter int SEG_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step,
    input  logic             wide,
    output logic [2*SEG_W-1:0] value
);

    logic [SEG_W-1:0] lo_q;
    logic [SEG_W-1:0] hi_q;
    logic             lo_full;

    assign lo_full = &lo_q;

    // Low segment: advance on every step, wrapping naturally.
    always_ff @(posedge clk) begin
        if (!rst_n)    lo_q <= '0;
        else if (step) lo_q <= lo_q + SEG_W'(1);
    end

    // High segment: advance on a low carry while wide.
    always_ff @(posedge clk) begin
        if (!rst_n)                       hi_q <= '0;
        else if (step && wide && lo_full) hi_q <= hi_q + SEG_W'(1);
    end

    assign value = {(wide ? hi_q : {SEG_W{1'b0}}), lo_q};

endmodule

// File: rtl/event_counter.sv
// Event counter top: control register, pin synchroniser, edge detector and
// two-segment counter. Counts cycle ticks or selected pin edges.
// Assumes cycle_tick is synchronous to clk and ext_pin is asynchronous.
module event_counter #(
    parameter int SEG_W       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 ctrl_we,
    input  logic [7:0]           ctrl_wdata,
    input  logic                 cycle_tick,
    input  logic                 ext_pin,
    output logic [7:0]           ctrl_q,
    output logic [2*SEG_W-1:0]   count_q,
    output logic                 pin_is_gpio
);
    import evc_pkg::*;

    evc_cfg_t cfg;
    logic     pin_sync;
    logic     pin_hit;
    logic     step;

    evc_ctrl u_ctrl (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (ctrl_we),
        .wdata (ctrl_wdata),
        .cfg   (cfg),
        .rdata (ctrl_q)
    );

    evc_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (ext_pin),
        .sync_out (pin_sync)
    );

    evc_edge u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .level    (pin_sync),
        .sel_fall (cfg.edge_fall),
        .hit      (pin_hit)
    );

    // Pick the event source and gate it with the enable.
    always_comb begin
        step = cfg.en & (cfg.src_ext ? pin_hit : cycle_tick);
    end

    evc_count #(.SEG_W(SEG_W)) u_count (
        .clk   (clk),
        .rst_n (rst_n),
        .step  (step),
        .wide  (cfg.wide),
        .value (count_q)
    );

    assign pin_is_gpio = ~cfg.src_ext;

endmodule

// File: rtl/evc_checker.sv
// Temporal checks on the event counter ports, attached by bind.
module evc_checker #(
    parameter int SEG_W = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic               ctrl_we,
    input logic [7:0]         ctrl_q,
    input logic               ext_pin,
    input logic [2*SEG_W-1:0] count_q
);
    localparam int CW = 2 * SEG_W;

    logic [CW-1:0] nxt;
    logic [2:0]    age;

    // Next legal count for the current mode.
    always_comb begin
        if (ctrl_q[7]) nxt = count_q + CW'(1);
        else           nxt = {{SEG_W{1'b0}}, count_q[SEG_W-1:0] + SEG_W'(1)};
    end

    // Cycles since reset, saturating, to keep pin history checks in range.
    always_ff @(posedge clk) begin
        if (!rst_n)        age <= '0;
        else if (age != 3'd7) age <= age + 3'd1;
    end

    // R1: disabled and unwritten means the count holds.
    a_r1_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl_q[6] && !ctrl_we) |=> $stable(count_q));

    // R10: one step at most, wrapping by mode (R5, R6).
    a_r10_single_step: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q[6] && !ctrl_we) |=> (count_q == $past(count_q)) || (count_q == $past(nxt)));

    // R5: narrow mode reads a zero high byte.
    a_r5_narrow_hi: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_q[7] |-> (count_q[CW-1:SEG_W] == '0));

    // R3: a quiet pin gives no count from the external source.
    a_r3_quiet_pin: assert property (@(posedge clk) disable iff (!rst_n)
        (age >= 3'd4 && ctrl_q[5] && !ctrl_we && ($past(ext_pin, 1) == $past(ext_pin, 2)))
        |-> ##2 $stable(count_q));

    // R9: reset clears the count and control byte.
    a_r9_reset: assert property (@(posedge clk)
        !rst_n |=> (count_q == '0) && (ctrl_q == 8'h00));

endmodule

bind event_counter evc_checker #(.SEG_W(SEG_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .ctrl_we (ctrl_we),
    .ctrl_q  (ctrl_q),
    .ext_pin (ext_pin),
    .count_q (count_q)
);

// File: tb/event_counter_tb.sv
module event_counter_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ctrl_we = 1'b0;
    logic [7:0]  ctrl_wdata = 8'h00;
    logic        cycle_tick = 1'b0;
    logic        ext_pin = 1'b0;
    logic [7:0]  ctrl_q;
    logic [15:0] count_q;
    logic        pin_is_gpio;

    int checks = 0;
    int fails  = 0;

    // Model state
    logic [7:0] m_ctrl = 8'h00;
    logic [7:0] m_lo = 8'h00;
    logic [7:0] m_hi = 8'h00;
    logic       m_s1 = 1'b0, m_s2 = 1'b0, m_h = 1'b0;

    always #5 clk = ~clk;

    event_counter dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .ctrl_we     (ctrl_we),
        .ctrl_wdata  (ctrl_wdata),
        .cycle_tick  (cycle_tick),
        .ext_pin     (ext_pin),
        .ctrl_q      (ctrl_q),
        .count_q     (count_q),
        .pin_is_gpio (pin_is_gpio)
    );

    function automatic logic [15:0] exp_count();
        return m_ctrl[7] ? {m_hi, m_lo} : {8'h00, m_lo};
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    // One cycle: drive at negedge, update model at posedge, compare at negedge.
    task automatic step(input bit rn, input bit we, input logic [7:0] wd,
                        input bit tick, input bit pin, input string tag);
        logic ev;
        rst_n = rn; ctrl_we = we; ctrl_wdata = wd; cycle_tick = tick; ext_pin = pin;
        @(posedge clk);
        if (!rn) begin
            m_ctrl = 8'h00; m_lo = 8'h00; m_hi = 8'h00;
            m_s1 = 1'b0; m_s2 = 1'b0; m_h = 1'b0;
        end else begin
            if (m_ctrl[5]) ev = m_ctrl[4] ? (m_h & ~m_s2) : (~m_h & m_s2);
            else           ev = tick;
            if (m_ctrl[6] && ev) begin
                if (m_ctrl[7] && m_lo == 8'hFF) m_hi = m_hi + 8'd1;
                m_lo = m_lo + 8'd1;
            end
            m_h = m_s2; m_s2 = m_s1; m_s1 = pin;
            if (we) m_ctrl = wd & 8'hF0;
        end
        @(negedge clk);
        chk(count_q == exp_count(), tag, {16'h0, count_q}, {16'h0, exp_count()});
        chk(ctrl_q == m_ctrl, "R7", {24'h0, ctrl_q}, {24'h0, m_ctrl});
        chk(pin_is_gpio == ~m_ctrl[5], "R4", {31'h0, pin_is_gpio}, {31'h0, ~m_ctrl[5]});
    endtask

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        logic [15:0] snap;
        @(negedge clk);
        // R9: reset state
        step(1'b0, 1'b0, 8'h00, 1'b0, 1'b0, "R9");
        step(1'b0, 1'b0, 8'h00, 1'b1, 1'b1, "R9");
        chk(count_q == 16'h0 && ctrl_q == 8'h00, "R9", {16'h0, count_q}, 32'h0);

        // Sweep all 16 configurations, spare bits set (R7 ignores them).
        for (int cfg = 0; cfg < 16; cfg++) begin
            string tg;
            tg = (cfg[2] == 1'b0) ? "R1" : (cfg[1] ? "R3" : "R2");
            step(1'b1, 1'b1, {cfg[3:0], 4'hA}, 1'b0, ext_pin, "R7");
            for (int i = 0; i < 48; i++)
                step(1'b1, 1'b0, 8'h00, (i % 3) != 1, ((i / (1 + cfg % 3)) % 2) == 1, tg);
        end

        // R5: narrow wrap
        step(1'b0, 1'b0, 8'h00, 1'b0, 1'b0, "R9");
        step(1'b1, 1'b1, 8'h40, 1'b0, 1'b0, "R7");
        for (int i = 0; i < 255; i++) step(1'b1, 1'b0, 8'h00, 1'b1, 1'b0, "R5");
        chk(count_q == 16'h00FF, "R5", {16'h0, count_q}, 32'hFF);
        step(1'b1, 1'b0, 8'h00, 1'b1, 1'b0, "R5");
        chk(count_q == 16'h0000, "R5", {16'h0, count_q}, 32'h0);

        // R6: wide carry and wrap
        step(1'b0, 1'b0, 8'h00, 1'b0, 1'b0, "R9");
        step(1'b1, 1'b1, 8'hC0, 1'b0, 1'b0, "R7");
        for (int i = 0; i < 256; i++) step(1'b1, 1'b0, 8'h00, 1'b1, 1'b0, "R6");
        chk(count_q == 16'h0100, "R6", {16'h0, count_q}, 32'h100);
        for (int i = 0; i < 65279; i++) step(1'b1, 1'b0, 8'h00, 1'b1, 1'b0, "R6");
        chk(count_q == 16'hFFFF, "R6", {16'h0, count_q}, 32'hFFFF);
        step(1'b1, 1'b0, 8'h00, 1'b1, 1'b0, "R6");
        chk(count_q == 16'h0000, "R6", {16'h0, count_q}, 32'h0);

        // R8: enable while pin already high, rising edge selected
        step(1'b0, 1'b0, 8'h00, 1'b0, 1'b0, "R9");
        step(1'b1, 1'b1, 8'h20, 1'b0, 1'b1, "R8");
        for (int i = 0; i < 6; i++) step(1'b1, 1'b0, 8'h00, 1'b0, 1'b1, "R8");
        step(1'b1, 1'b1, 8'h60, 1'b0, 1'b1, "R8");
        for (int i = 0; i < 8; i++) step(1'b1, 1'b0, 8'h00, 1'b1, 1'b1, "R8");
        chk(count_q == 16'h0000, "R8", {16'h0, count_q}, 32'h0);

        // R3 latency and R10 one count per held edge
        for (int i = 0; i < 4; i++) step(1'b1, 1'b0, 8'h00, 1'b0, 1'b0, "R3");
        snap = count_q;
        step(1'b1, 1'b0, 8'h00, 1'b0, 1'b1, "R3");
        step(1'b1, 1'b0, 8'h00, 1'b0, 1'b1, "R3");
        chk(count_q == snap, "R3", {16'h0, count_q}, {16'h0, snap});
        step(1'b1, 1'b0, 8'h00, 1'b0, 1'b1, "R3");
        chk(count_q == snap + 16'd1, "R3", {16'h0, count_q}, {16'h0, snap + 16'd1});
        for (int i = 0; i < 10; i++) step(1'b1, 1'b0, 8'h00, 1'b1, 1'b1, "R10");
        chk(count_q == snap + 16'd1, "R10", {16'h0, count_q}, {16'h0, snap + 16'd1});

        // R3 falling polarity
        step(1'b1, 1'b1, 8'h70, 1'b0, 1'b1, "R7");
        for (int i = 0; i < 6; i++) step(1'b1, 1'b0, 8'h00, 1'b0, 1'b0, "R3");
        chk(count_q == snap + 16'd2, "R3", {16'h0, count_q}, {16'h0, snap + 16'd2});

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule